// File: doc/BRIEF.md
# Table-Programmed PLA Evaluator

This block is a purely combinational programmable logic array. The AND plane holds one row per product term. Each row gives a two-bit symbol for every input, and the symbol says whether the term needs that input high, needs it low, or ignores it. The OR plane is a connection matrix that picks which product terms feed each output. Every output is the OR of its connected product terms, evaluated against the present input vector. Both planes come in as flat configuration vectors, so the block computes minimised sum-of-products functions rather than storing a full minterm table.

A parameter switches the block into a fixed-grouping mode. In that mode output `o` owns its own contiguous group of terms, no term is shared, and the OR-plane vector is ignored. The default build has three inputs (A on `in_vec[2]`, B on `in_vec[1]`, C on `in_vec[0]`), five product terms and four outputs. With a suitable configuration it yields, for example, output 0 = A'B' + AC'.

Top module: `pla_eval`

## Requirements
- R1: The symbol for term t and input i is `and_cfg[2*(t*N_IN+i) +: 2]`. Code 2'b01 keeps the term true only when that input is 1, and code 2'b10 keeps it true only when that input is 0.
- R2: Code 2'b11 leaves a term independent of that input. A term whose symbols are all 2'b11 is constant 1.
- R3: Code 2'b00 in any position forces that term to 0 for every input vector.
- R4: In shared mode (PAL_MODE=0), bit `or_cfg[o*N_TERM+t]` set to 1 ORs term t into output o, and set to 0 keeps it out.
- R5: An output with no connected term that is true evaluates to 0, and this includes an output with no connections at all.
- R6: In shared mode one term may feed several outputs at once, and each of those outputs sees it.
- R7: In grouped mode (PAL_MODE=1), output o is the OR of terms o*G through o*G+G-1, with G = N_TERM/N_OUT. In this mode `or_cfg` has no effect on any output.
- R8: Outputs hold no state. They reflect the present inputs and configuration within the same cycle those values are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_vec | input | N_IN | Logic inputs; the highest index is variable A |
| and_cfg | input | 2*N_IN*N_TERM | Product-term symbol table, two bits per input per term |
| or_cfg | input | N_TERM*N_OUT | Term-to-output connection matrix (shared mode only) |
| out_vec | output | N_OUT | Sum-of-products results |

## Verification
Two functions can meet in one evaluation: a term shared between outputs and a constant-1 term made of don't-care symbols. The bench provokes this by making the all-dash term feed one output on its own while a shared term also feeds that output's neighbour. It then sweeps all eight input vectors and compares both outputs with minterm tables written by hand. A further sweep places a kill symbol in one term that an output also shares. The bench judges the result by checking that only that term's minterms disappear from the output.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef logic [1:0] sym_t;

  localparam sym_t SYM_KILL = 2'b00;
  localparam sym_t SYM_HIGH = 2'b01;
  localparam sym_t SYM_LOW  = 2'b10;
  localparam sym_t SYM_ANY  = 2'b11;

  // one literal of a product term: bit 0 admits a high input, bit 1 a low one
  function automatic logic sym_pass(input sym_t s, input logic v);
    return (s[0] & v) | (s[1] & ~v);
  endfunction

  // index of the first term owned by an output in grouped mode
  function automatic int group_base(input int o, input int grp);
    return o * grp;
  endfunction

endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5
) (
  input  logic [N_IN-1:0]          in_vec,
  input  logic [2*N_IN*N_TERM-1:0] and_cfg,
  output logic [N_TERM-1:0]        term_hit
);

  localparam int ROW_W = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [ROW_W-1:0] row;
    logic             hit;

    assign row = and_cfg[t*ROW_W +: ROW_W];

    always_comb begin
      hit = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        hit = hit & sym_pass(row[2*i +: 2], in_vec[i]);
      end
    end

    assign term_hit[t] = hit;
  end

  // checks against the row table, separate from the per-term logic
  always_comb begin
    for (int t = 0; t < N_TERM; t++) begin
      for (int i = 0; i < N_IN; i++) begin
        // R1
        r1_literal_chk: assert (!(term_hit[t] && and_cfg[t*ROW_W+2*i +: 2] == SYM_HIGH && !in_vec[i]));
        // R3
        r3_kill_chk: assert (!(term_hit[t] && and_cfg[t*ROW_W+2*i +: 2] == SYM_KILL));
      end
      // R2
      r2_alldash_chk: assert (!(&and_cfg[t*ROW_W +: ROW_W]) || term_hit[t]);
    end
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int N_TERM   = 5,
  parameter int N_OUT    = 4,
  parameter bit PAL_MODE = 1'b0
) (
  input  logic [N_TERM-1:0]       term_hit,
  input  logic [N_TERM*N_OUT-1:0] or_cfg,
  output logic [N_OUT-1:0]        out_vec
);

  localparam int GRP = N_TERM / N_OUT;

  logic [N_OUT-1:0][N_TERM-1:0] conn;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    if (PAL_MODE) begin : g_fixed
      for (genvar t = 0; t < N_TERM; t++) begin : g_bit
        assign conn[o][t] = (t >= group_base(o, GRP)) && (t < group_base(o, GRP) + GRP);
      end
    end else begin : g_shared
      assign conn[o] = or_cfg[o*N_TERM +: N_TERM];
    end
    assign out_vec[o] = |(term_hit & conn[o]);
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      // R5
      r5_empty_low_chk: assert (|(term_hit & conn[o]) || !out_vec[o]);
      for (int t = 0; t < N_TERM; t++) begin
        // R6
        r6_shared_term_chk: assert (!(term_hit[t] && conn[o][t]) || out_vec[o]);
      end
    end
  end

endmodule

// File: rtl/pla_eval.sv
module pla_eval
  import pla_pkg::*;
#(
  parameter int N_IN     = 3,
  parameter int N_TERM   = 5,
  parameter int N_OUT    = 4,
  parameter bit PAL_MODE = 1'b0
) (
  input  logic [N_IN-1:0]          in_vec,
  input  logic [2*N_IN*N_TERM-1:0] and_cfg,
  input  logic [N_TERM*N_OUT-1:0]  or_cfg,
  output logic [N_OUT-1:0]         out_vec
);

  logic [N_TERM-1:0] term_hit;

  pla_and_plane #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM)
  ) i_and_plane (
    .in_vec   (in_vec),
    .and_cfg  (and_cfg),
    .term_hit (term_hit)
  );

  pla_or_plane #(
    .N_TERM   (N_TERM),
    .N_OUT    (N_OUT),
    .PAL_MODE (PAL_MODE)
  ) i_or_plane (
    .term_hit (term_hit),
    .or_cfg   (or_cfg),
    .out_vec  (out_vec)
  );

  always_comb begin
    // R8
    r8_no_term_chk: assert (|term_hit || out_vec == '0);
  end

endmodule

// File: tb/test_pla_eval.sv
`timescale 1ns/1ps
module test_pla_eval;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]  a_in  = '0;
  logic [29:0] a_and = '0;
  logic [19:0] a_or  = '0;
  logic [3:0]  a_out;

  logic [2:0]  p_in  = '0;
  logic [47:0] p_and = '0;
  logic [31:0] p_or  = '0;
  logic [3:0]  p_out;

  pla_eval #(.N_IN(3), .N_TERM(5), .N_OUT(4), .PAL_MODE(1'b0)) i_pla_eval (
    .in_vec(a_in), .and_cfg(a_and), .or_cfg(a_or), .out_vec(a_out));

  pla_eval #(.N_IN(3), .N_TERM(8), .N_OUT(4), .PAL_MODE(1'b1)) i_pla_eval_pal (
    .in_vec(p_in), .and_cfg(p_and), .or_cfg(p_or), .out_vec(p_out));

  typedef struct {
    bit        pal;
    logic [3:0] exp;
    string     tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;

  // symbols for one term, listed as A, B, C
  function automatic logic [5:0] row3(input logic [1:0] sa, input logic [1:0] sb, input logic [1:0] sc);
    return {sa, sb, sc};
  endfunction

  // independent evaluator: a term dies on the first literal it fails
  function automatic logic [3:0] ref_eval(input logic [47:0] andc, input logic [31:0] orc,
                                          input logic [2:0] v, input int nterm, input bit pal);
    logic [3:0] r;
    logic alive;
    r = '0;
    for (int t = 0; t < nterm; t++) begin
      alive = 1'b1;
      for (int i = 0; i < 3; i++) begin
        case (andc[6*t + 2*i +: 2])
          2'b00: alive = 1'b0;
          2'b01: if (v[i] == 1'b0) alive = 1'b0;
          2'b10: if (v[i] == 1'b1) alive = 1'b0;
          default: ;
        endcase
      end
      for (int o = 0; o < 4; o++) begin
        if (pal) begin
          if (t / 2 == o && alive) r[o] = 1'b1;
        end else begin
          if (orc[o*nterm + t] && alive) r[o] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  // driver: apply one input vector and queue what must appear
  task automatic apply(input bit pal, input logic [2:0] v, input logic [3:0] exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    if (pal) p_in = v; else a_in = v;
    it.pal = pal; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  // monitor: compare half a cycle after the inputs moved
  initial begin
    item_t it;
    logic [3:0] got;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        got = it.pal ? p_out : a_out;
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s in=%b actual=%b expected=%b", it.tag,
                   it.pal ? p_in : a_in, got, it.exp);
        end
      end
    end
  end

  task automatic sweep_masks(input logic [7:0] m0, input logic [7:0] m1,
                             input logic [7:0] m2, input logic [7:0] m3, input string tag);
    for (int v = 0; v < 8; v++) begin
      apply(1'b0, 3'(v), {m3[v], m2[v], m1[v], m0[v]}, tag);
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R5 R8: all-zero configuration gives all-zero outputs
    @(negedge clk);
    #1;
    total++;
    if (a_out !== 4'b0) begin
      bad++;
      $display("FAIL R5 initial actual=%b expected=%b", a_out, 4'b0);
    end

    // default table: T0=A'B' T1=AC' T2=BC T3=AB'C T4=A'BC'
    a_and = {row3(2'b10, 2'b01, 2'b10), row3(2'b01, 2'b10, 2'b01), row3(2'b11, 2'b01, 2'b01),
             row3(2'b01, 2'b11, 2'b10), row3(2'b10, 2'b10, 2'b11)};
    // F0=T0|T1, F1=T2|T3, F2=T1|T4, F3 unconnected
    a_or = {5'b00000, 5'b10010, 5'b01100, 5'b00011};
    // R1 R4 R5 R6: F0 = {0,1,4,6}, F1 = {3,5,7}, F2 = {2,4,6}, F3 empty
    sweep_masks(8'h53, 8'hA8, 8'h54, 8'h00, "R1_R4_R6");

    // R2 R6: T4 becomes all-dash and feeds F3 alone plus F2 (shared with T1)
    a_and[29:24] = 6'b111111;
    a_or[19:15] = 5'b10000;
    sweep_masks(8'h53, 8'hA8, 8'hFF, 8'hFF, "R2_R6");

    // R3: kill symbol on C of T0; F0 loses minterms 0 and 1
    a_and[29:24] = row3(2'b10, 2'b01, 2'b10);
    a_or[19:15] = 5'b00000;
    a_and[1:0] = 2'b00;
    sweep_masks(8'h50, 8'hA8, 8'h54, 8'h00, "R3");

    // R5: no connections at all
    a_or = '0;
    sweep_masks(8'h00, 8'h00, 8'h00, 8'h00, "R5");

    // R1 R2 R3 R4 R8: random tables against the independent evaluator
    for (int k = 0; k < 24; k++) begin
      a_and = 30'($urandom) | 30'($urandom);
      a_or = 20'($urandom);
      for (int v = 0; v < 8; v++) begin
        apply(1'b0, 3'(v), ref_eval({18'b0, a_and}, {12'b0, a_or}, 3'(v), 5, 1'b0), "R8_random");
      end
    end

    // R7: grouped mode, outputs follow their own term pairs whatever or_cfg holds
    for (int k = 0; k < 12; k++) begin
      p_and = {$urandom, $urandom} | {$urandom, $urandom};
      p_or = (k % 2 == 0) ? '1 : 32'($urandom);
      for (int v = 0; v < 8; v++) begin
        apply(1'b1, 3'(v), ref_eval(p_and, p_or, 3'(v), 8, 1'b1), "R7");
      end
    end

    // R7: or_cfg toggled with inputs held; output must not move
    p_and = {8{row3(2'b11, 2'b11, 2'b01)}};
    p_or = '0;
    apply(1'b1, 3'b001, 4'b1111, "R7_or_ignored");
    p_or = '1;
    apply(1'b1, 3'b001, 4'b1111, "R7_or_ignored");
    apply(1'b1, 3'b000, 4'b0000, "R7_or_ignored");

    @(negedge clk);
    #1;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard actual=%0d expected=0", q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule